// File: doc/BRIEF.md
# Video Memory Cycle Arbiter

This block divides each video line into fixed memory cycles and gives each cycle an owner. The owner is a display fetch, a refresh read, or a CPU access. A line is 342 clocks long, cut into 171 memory cycles of two clocks each. There are no burst accesses. CPU reads and writes may use only the window cycles, and how often windows appear depends on the display mode latched for the line. Graphics lines give the CPU one window in sixteen cycles. Text lines give one in three. Multicolor lines give one in four, because the unused color fetches are handed to the CPU.

Vertical border lines and display-off lines share one schedule. Every other memory cycle is a CPU window, the first 32 of the remaining cycles are refresh reads, and the rest stay idle. Active lines never refresh. The CPU side holds a one-entry request buffer. A request is parked there, busy is raised, and the request is issued in the first window that opens after it was taken.

Top module: `vdp_mem_arb`

## Requirements
- R1: A line is 342 clocks, made of memory cycles m = 0..170 with m = clock-in-line / 2. `acc_type_o` is constant across both clocks of a memory cycle, with codes 0 idle, 1 display fetch, 2 refresh, 3 CPU read, 4 CPU write.
- R2: On a graphics line (`mode_i` 0 or 3), cycle m is a CPU window when m mod 16 = 0. Every other cycle is a display fetch.
- R3: On a text line (`mode_i` 1), cycle m is a CPU window when m mod 3 = 0. Every other cycle is a display fetch.
- R4: On a multicolor line (`mode_i` 2), cycle m is a CPU window when m mod 4 = 0. Every other cycle is a display fetch.
- R5: A line is blank when `vblank_i` = 1 or `disp_en_i` = 0. On a blank line, even cycles are CPU windows and odd cycles m = 1..63 (32 of them) are refresh reads. The remaining odd cycles are idle. Active lines carry no refresh.
- R6: Mode and blank state are sampled on the last clock of a line and govern the whole next line, so a change in the middle of a line has no effect until the next line. The first line after reset is blank.
- R7: A request (`req_i` high for one clock, with `we_i`) is taken at the next clock edge, and `busy_o` is high from the following clock. `grant_o` pulses on the first clock of the first window cycle that starts after capture. That cycle shows code 3 (read) or 4 (write) on both of its clocks, and `busy_o` drops on the clock after the grant.
- R8: A request that arrives while `busy_o` is high is ignored. It causes no later grant and no access of its type.
- R9: A window cycle with nothing pending shows code 0. `grant_o` is never high outside the first clock of a window cycle.
- R10: During reset `grant_o` = 0, `busy_o` = 0 and the line position is clock 0 of a blank line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Video clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | CPU access request, one-clock pulse |
| we_i | input | 1 | 1 = write, 0 = read, taken together with req_i |
| mode_i | input | 2 | Display mode: 0/3 graphics, 1 text, 2 multicolor |
| vblank_i | input | 1 | Line is in the vertical border |
| disp_en_i | input | 1 | Display enabled; 0 gives the blank schedule |
| grant_o | output | 1 | CPU access issued in this cycle |
| acc_type_o | output | 3 | Owner of the current memory cycle |
| busy_o | output | 1 | A CPU request is waiting for a window |

## Verification
`acc_type_o` is a function of the clock's position in the line and the schedule latched at the previous line end. The bench keeps its own line position counter, started from the same reset release, and compares every clock of whole lines against a schedule it computes from the mode period. A request driven in clock h is taken at the next edge. The bench therefore expects `busy_o` from clock h+1 and expects the grant at the first even clock after h whose memory cycle is a window, then checks the code on that clock and the next one. A mode change is driven partway through a line, and the rest of that line is still compared against the old schedule.

// File: rtl/vdp_arb_pkg.sv
package vdp_arb_pkg;
  typedef enum logic [2:0] {
    ACC_IDLE   = 3'd0,
    ACC_DISP   = 3'd1,
    ACC_RFSH   = 3'd2,
    ACC_CPU_RD = 3'd3,
    ACC_CPU_WR = 3'd4
  } acc_t;

  typedef enum logic [1:0] {
    MODE_GFX     = 2'd0,
    MODE_TXT     = 2'd1,
    MODE_MC      = 2'd2,
    MODE_GFX_ALT = 2'd3
  } mode_t;
endpackage

// File: rtl/vdp_arb_line_timer.sv
module vdp_arb_line_timer #(
  parameter int LINE_CLKS = 342,
  localparam int HW = $clog2(LINE_CLKS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [HW-1:0] hcnt_o,
  output logic          line_end_o,
  output logic          cyc_end_o
);
  logic [HW-1:0] hcnt_q;

  assign line_end_o = (hcnt_q == HW'(LINE_CLKS - 1));
  assign cyc_end_o  = hcnt_q[0];
  assign hcnt_o     = hcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hcnt_q <= '0;
    else if (line_end_o) hcnt_q <= '0;
    else                 hcnt_q <= hcnt_q + HW'(1);
  end
endmodule

// File: rtl/vdp_arb_window_gen.sv
module vdp_arb_window_gen
  import vdp_arb_pkg::*;
#(
  parameter int GFX_PERIOD       = 16,
  parameter int TXT_PERIOD       = 3,
  parameter int MC_PERIOD        = 4,
  parameter int BLANK_PERIOD     = 2,
  parameter int REFRESH_PER_LINE = 32
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cyc_end_i,
  input  logic  line_end_i,
  input  logic  line_blank_i,
  input  mode_t line_mode_i,
  output logic  win_o,
  output logic  rfsh_o
);
  localparam int MAX_A = (GFX_PERIOD > TXT_PERIOD) ? GFX_PERIOD : TXT_PERIOD;
  localparam int MAX_B = (MC_PERIOD > BLANK_PERIOD) ? MC_PERIOD : BLANK_PERIOD;
  localparam int MAXP  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int WW    = (MAXP > 2) ? $clog2(MAXP) : 1;
  localparam int RW    = $clog2(REFRESH_PER_LINE + 1);

  logic [WW:0]   period;
  logic [WW-1:0] wcnt_q;
  logic          wrap;

  always_comb begin
    if (line_blank_i) period = (WW+1)'(BLANK_PERIOD);
    else begin
      unique case (line_mode_i)
        MODE_TXT: period = (WW+1)'(TXT_PERIOD);
        MODE_MC:  period = (WW+1)'(MC_PERIOD);
        default:  period = (WW+1)'(GFX_PERIOD);
      endcase
    end
  end

  assign wrap  = ({1'b0, wcnt_q} == period - (WW+1)'(1));
  assign win_o = (wcnt_q == '0);

  // window phase restarts with every line
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         wcnt_q <= '0;
    else if (line_end_i) wcnt_q <= '0;
    else if (cyc_end_i)  wcnt_q <= wrap ? '0 : wcnt_q + WW'(1);
  end

  generate
    if (REFRESH_PER_LINE > 0) begin : g_rfsh
      logic [RW-1:0] rcnt_q;
      assign rfsh_o = line_blank_i && !win_o && (rcnt_q < RW'(REFRESH_PER_LINE));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                    rcnt_q <= '0;
        else if (line_end_i)            rcnt_q <= '0;
        else if (cyc_end_i && rfsh_o)   rcnt_q <= rcnt_q + RW'(1);
      end
    end else begin : g_no_rfsh
      assign rfsh_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/vdp_arb_cpu_buf.sv
module vdp_arb_cpu_buf (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic we_i,
  input  logic grant_i,
  output logic pend_o,
  output logic we_o
);
  logic pend_q, we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      we_q   <= 1'b0;
    end else if (grant_i) begin
      pend_q <= 1'b0;
    end else if (req_i && !pend_q) begin
      pend_q <= 1'b1;
      we_q   <= we_i;
    end
  end

  assign pend_o = pend_q;
  assign we_o   = we_q;
endmodule

// File: rtl/vdp_mem_arb.sv
module vdp_mem_arb
  import vdp_arb_pkg::*;
#(
  parameter int LINE_CLKS        = 342,
  parameter int GFX_PERIOD       = 16,
  parameter int TXT_PERIOD       = 3,
  parameter int MC_PERIOD        = 4,
  parameter int BLANK_PERIOD     = 2,
  parameter int REFRESH_PER_LINE = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       we_i,
  input  logic [1:0] mode_i,
  input  logic       vblank_i,
  input  logic       disp_en_i,
  output logic       grant_o,
  output logic [2:0] acc_type_o,
  output logic       busy_o
);
  localparam int HW = $clog2(LINE_CLKS);

  logic [HW-1:0] hcnt;
  logic          line_end, cyc_end, phase;
  logic          win, rfsh, pend, pend_we;
  logic          line_blank_q;
  mode_t         line_mode_q;
  acc_t          type_d, type_q;

  vdp_arb_line_timer #(.LINE_CLKS(LINE_CLKS)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hcnt_o     (hcnt),
    .line_end_o (line_end),
    .cyc_end_o  (cyc_end)
  );

  // schedule is fixed for a whole line
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_blank_q <= 1'b1;
      line_mode_q  <= MODE_GFX;
    end else if (line_end) begin
      line_blank_q <= vblank_i | ~disp_en_i;
      line_mode_q  <= mode_t'(mode_i);
    end
  end

  vdp_arb_window_gen #(
    .GFX_PERIOD       (GFX_PERIOD),
    .TXT_PERIOD       (TXT_PERIOD),
    .MC_PERIOD        (MC_PERIOD),
    .BLANK_PERIOD     (BLANK_PERIOD),
    .REFRESH_PER_LINE (REFRESH_PER_LINE)
  ) u_win (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cyc_end_i    (cyc_end),
    .line_end_i   (line_end),
    .line_blank_i (line_blank_q),
    .line_mode_i  (line_mode_q),
    .win_o        (win),
    .rfsh_o       (rfsh)
  );

  assign phase   = hcnt[0];
  assign grant_o = win && !phase && pend;

  vdp_arb_cpu_buf u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .grant_i (grant_o),
    .pend_o  (pend),
    .we_o    (pend_we)
  );

  always_comb begin
    if (win)               type_d = pend ? (pend_we ? ACC_CPU_WR : ACC_CPU_RD) : ACC_IDLE;
    else if (rfsh)         type_d = ACC_RFSH;
    else if (line_blank_q) type_d = ACC_IDLE;
    else                   type_d = ACC_DISP;
  end

  // owner decided on the first clock, held on the second
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     type_q <= ACC_IDLE;
    else if (!phase) type_q <= type_d;
  end

  assign acc_type_o = phase ? type_q : type_d;
  assign busy_o     = pend;
endmodule

// File: rtl/vdp_mem_arb_chk.sv
module vdp_mem_arb_chk #(
  parameter int LINE_CLKS = 342,
  localparam int HW = $clog2(LINE_CLKS)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          grant_o,
  input logic          busy_o,
  input logic [2:0]    acc_type_o,
  input logic [HW-1:0] hcnt_i,
  input logic          line_blank_i
);
  AST_LINE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hcnt_i == HW'(LINE_CLKS - 1)) |=> (hcnt_i == '0)); // R1
  AST_TYPE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hcnt_i[0] |=> $stable(acc_type_o)); // R1
  AST_GRANT_TYPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> (acc_type_o == 3'd3 || acc_type_o == 3'd4)); // R7
  AST_GRANT_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> busy_o); // R7
  AST_GRANT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |=> !busy_o); // R7
  AST_BUSY_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_i)); // R7
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !grant_o) |=> busy_o); // R8
  AST_RFSH_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_type_o == 3'd2) |-> line_blank_i); // R5
  AST_GRANT_FIRST_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> !hcnt_i[0]); // R9
endmodule

bind vdp_mem_arb vdp_mem_arb_chk #(.LINE_CLKS(LINE_CLKS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .grant_o      (grant_o),
  .busy_o       (busy_o),
  .acc_type_o   (acc_type_o),
  .hcnt_i       (hcnt),
  .line_blank_i (line_blank_q)
);

// File: tb/vdp_mem_arb_test.sv
`timescale 1ns/1ps
module vdp_mem_arb_test;
  localparam int LINE = 342;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       vblank = 1'b1, disp_en = 1'b1;
  logic       grant, busy;
  logic [2:0] acc;

  int n_tests = 0, n_fail = 0;
  int hc = 0, cur_kind = 0, clks = 0;

  always #2.5 clk = ~clk;

  vdp_mem_arb uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .mode_i(mode),
    .vblank_i(vblank), .disp_en_i(disp_en),
    .grant_o(grant), .acc_type_o(acc), .busy_o(busy)
  );

  // kinds: 0 blank, 1 graphics, 2 text, 3 multicolor
  function automatic int kind_of(logic vb, logic en, logic [1:0] md);
    if (vb || !en) return 0;
    if (md == 2'd1) return 2;
    if (md == 2'd2) return 3;
    return 1;
  endfunction

  function automatic int period_of(int k);
    case (k)
      0: return 2;
      2: return 3;
      3: return 4;
      default: return 16;
    endcase
  endfunction

  function automatic bit is_win(int k, int h);
    return ((h % 2) == 0) && (((h / 2) % period_of(k)) == 0);
  endfunction

  function automatic int exp_type(int k, int h);
    int m;
    m = h / 2;
    if ((m % period_of(k)) == 0) return 0;
    if (k == 0) return ((m % 2 == 1) && (m < 64)) ? 2 : 0;
    return 1;
  endfunction

  function automatic int next_win(int k, int h);
    for (int x = h + 1; x < LINE; x++) if (is_win(k, x)) return x;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc <= 0; cur_kind <= 0;
    end else begin
      if (hc == LINE - 1) begin
        hc <= 0;
        cur_kind <= kind_of(vblank, disp_en, mode);
      end else hc <= hc + 1;
    end
  end

  always @(posedge clk) begin
    clks <= clks + 1;
    if (clks > 20000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d clocks expected < 20000", clks);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(bit ok, string what, int act, int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, expv);
    end
  endtask

  task automatic wait_hc(int h);
    while (hc != h) @(negedge clk);
  endtask

  // checks a whole line without CPU traffic; optional mid-line mode change
  task automatic t_line(string tag, int exp_rfsh, int exp_win, int exp_disp,
                        int sw_hc, logic [1:0] sw_mode);
    int bad = 0, fa = 0, fe = 0, nr = 0, nw = 0, nd = 0, k;
    wait_hc(0);
    k = cur_kind;
    for (int i = 0; i < LINE; i++) begin
      if (hc == sw_hc) mode = sw_mode;
      if (acc != 3'(exp_type(k, hc)) || grant) begin
        if (bad == 0) begin fa = acc; fe = exp_type(k, hc); end
        bad++;
      end
      if (hc % 2 == 0) begin
        if (acc == 3'd2) nr++;
        if (acc == 3'd1) nd++;
        if (is_win(k, hc)) nw++;
      end
      @(negedge clk);
    end
    chk(bad == 0, {tag, " per-clock owner R1"}, fa, fe);
    chk(nr == exp_rfsh, {tag, " refresh count"}, nr, exp_rfsh);
    chk(nw == exp_win, {tag, " window count"}, nw, exp_win);
    chk(nd == exp_disp, {tag, " display count"}, nd, exp_disp);
  endtask

  task automatic t_cpu(string tag, int h, logic w);
    int wt, bad = 0, exp_code;
    wait_hc(h);
    wt = next_win(cur_kind, h);
    exp_code = w ? 4 : 3;
    req = 1'b1; we = w;
    @(negedge clk);
    req = 1'b0;
    while (hc != wt) begin
      if (!busy || grant) bad++;
      @(negedge clk);
    end
    chk(bad == 0, {tag, " R7 busy while waiting"}, bad, 0);
    chk(grant == 1'b1, {tag, " R7 grant at window"}, grant, 1);
    chk(acc == 3'(exp_code), {tag, " R7 type first clock"}, acc, exp_code);
    @(negedge clk);
    chk(acc == 3'(exp_code), {tag, " R1 type second clock"}, acc, exp_code);
    chk(!busy && !grant, {tag, " R7 busy cleared"}, busy, 0);
  endtask

  task automatic t_drop(int h);
    int bad = 0;
    wait_hc(h);
    req = 1'b1; we = 1'b0;
    @(negedge clk);
    we = 1'b1; // second request while busy
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    while (!grant) @(negedge clk);
    chk(acc == 3'd3, "R8 first request served as read", acc, 3);
    @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      if (grant || busy || acc == 3'd4) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R8 request during busy ignored", bad, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!grant && !busy, "R10 reset grant/busy", {grant, busy}, 0);
    chk(acc == 3'd0, "R10 reset owner idle", acc, 0);
    rst_n = 1'b1;

    vblank = 1'b0; mode = 2'd0;                 // next: graphics
    t_line("R5 R6 blank after reset", 32, 86, 0, -1, 2'd0);
    mode = 2'd1;                                // next: text
    t_line("R2 graphics", 0, 11, 160, -1, 2'd1);
    mode = 2'd2;                                // next: multicolor
    t_line("R3 text", 0, 57, 114, -1, 2'd2);
    disp_en = 1'b0; mode = 2'd0;                // next: display off
    t_line("R4 multicolor", 0, 43, 128, -1, 2'd0);
    disp_en = 1'b1;                             // next: graphics
    t_line("R5 display off", 32, 86, 0, -1, 2'd0);
    t_line("R6 mid-line change", 0, 11, 160, 100, 2'd1); // next: text
    t_cpu("R3 text read", 21, 1'b0);
    t_cpu("R3 text write", 101, 1'b1);
    t_drop(200);
    mode = 2'd0;                                // next: graphics
    wait_hc(0);
    t_cpu("R2 graphics read", 3, 1'b0);
    vblank = 1'b1;                              // next: blank
    wait_hc(0);
    t_cpu("R5 blank write", 10, 1'b1);
    wait_hc(40);
    chk(acc == 3'd0 && !grant, "R9 idle window", acc, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule